// File: doc/BRIEF.md
# Synchronous Serial Port with Collision Status

This block is an 8-bit synchronous serial shift port for a small CPU register bus. Writing the data register while the port is enabled and idle starts a transfer. The port drives a clock that idles high and shifts the byte out on SDO, most significant bit first. SDO changes on falling clock edges, and SDI is sampled on rising edges. After the transfer, reading the same data register returns the byte that came in. The serial clock comes from a fixed divider of the system clock, and all logic runs in the system clock domain.

A status register reports two things. The first is a done flag, which sets on the last rising serial clock edge. The second is a collision flag, which sets when software touches the data register in the middle of a transfer. The access is never blocked, so the data on the wire is corrupted. Both flags clear through a two-step sequence. Software first reads the status register while the done flag is set, and this arms an internal bit. It then reads or writes the data register. A collision flag that is set while the done flag is clear can only be removed by dropping the enable input.

Top module: `ssp_core`

## Requirements
- R1: After reset the status register reads 0x00, the data register reads 0x00, SCK is high and SDO is 0.
- R2: The status register is at bus address 0x0B, and the data register is at 0x0C. In the status register, bit 7 is the done flag, bit 6 is the collision flag, and bits 5..0 read 0. Any other address reads 0x00.
- R3: A write to 0x0C while enabled and idle starts a transfer. SCK idles high, and each half period of SCK lasts HALF system clocks. SDO changes on falling SCK edges and carries the written byte MSB first.
- R4: SDI is sampled on rising SCK edges, MSB first. After the transfer, a read of 0x0C returns the received byte.
- R5: The done flag sets at the system clock edge of the 8th rising SCK edge. That edge is 16*HALF clocks after the edge that commits the starting write.
- R6: A status read that sees done=1, followed by a read or write of 0x0C, clears both flags. An access to 0x0C with no such status read before it leaves the flags unchanged.
- R7: Once the first step is armed, accesses to other addresses do not cancel it.
- R8: A read or write of 0x0C after the first falling SCK edge and before done sets raises the collision flag. The access still takes effect: a write reloads the shift register and corrupts the outgoing data. An access before the first falling edge raises no collision.
- R9: If the flags are cleared before the last edge of the next byte, done sets again at that edge.
- R10: If the second clearing step falls inside the collision window of a new transfer, the collision flag ends set and the done flag ends clear.
- R11: While the collision flag is 1 and done is 0, only a low enable clears the collision flag. A low enable also clears the armed bit, aborts any transfer and returns SCK high.
- R12: A write to 0x0C while disabled loads the data register but starts no transfer.
- R13: Reset clears both flags at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| port_en | input | 1 | Port enable level |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address while bus_rd is high |
| sck | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
Read data is combinational, so each read shows the state left by the previous clock edge. Side effects such as arming, clearing and collision take hold at the edge that ends the read. A starting write commits at edge W. The first SCK fall comes at edge W+HALF, and done is due at edge W+16*HALF. The bench therefore checks status one edge before that point, expecting done clear, and again at that point, expecting done set. Collision stimuli are placed at least HALF+1 edges after the start so that they land inside the window, and pre-window stimuli are placed at W+1. All inputs are driven and all outputs sampled on falling clock edges.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [7:0] SSP_STAT_ADDR = 8'h0B;
  localparam logic [7:0] SSP_DATA_ADDR = 8'h0C;
  localparam int         SSP_DONE_BIT  = 7;
  localparam int         SSP_COLL_BIT  = 6;

  // Status word with only the two implemented bits populated.
  function automatic logic [7:0] status_word(input logic done, input logic coll);
    logic [7:0] w;
    w = 8'h00;
    w[SSP_DONE_BIT] = done;
    w[SSP_COLL_BIT] = coll;
    return w;
  endfunction
endpackage

// File: rtl/ssp_divider.sv
module ssp_divider #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (tick)  cnt <= '0;
    else            cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            start,
  input  logic            load,
  input  logic [BITS-1:0] load_data,
  input  logic            tick,
  input  logic            sdi,
  output logic            sck,
  output logic            sdo,
  output logic            busy,
  output logic            in_window,
  output logic            last_rise,
  output logic [BITS-1:0] shreg
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic [CW-1:0] bit_cnt;
  logic          fell_seen;
  logic          fall_ev, rise_ev;

  function automatic logic [BITS-1:0] shift_in(input logic [BITS-1:0] v, input logic b);
    return {v[BITS-2:0], b};
  endfunction

  assign fall_ev   = busy && tick && sck;
  assign rise_ev   = busy && tick && !sck;
  assign last_rise = rise_ev && (bit_cnt == LAST_BIT);
  assign in_window = busy && fell_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck       <= 1'b1;
      sdo       <= 1'b0;
      busy      <= 1'b0;
      fell_seen <= 1'b0;
      bit_cnt   <= '0;
      shreg     <= '0;
    end else if (!en) begin
      sck       <= 1'b1;
      busy      <= 1'b0;
      fell_seen <= 1'b0;
      bit_cnt   <= '0;
      if (load) shreg <= load_data;
    end else begin
      if (start) begin
        busy      <= 1'b1;
        fell_seen <= 1'b0;
        bit_cnt   <= '0;
      end else if (fall_ev) begin
        sck       <= 1'b0;
        sdo       <= shreg[BITS-1];
        fell_seen <= 1'b1;
      end else if (rise_ev) begin
        sck <= 1'b1;
        if (last_rise) begin
          busy      <= 1'b0;
          fell_seen <= 1'b0;
          bit_cnt   <= '0;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      // A bus write always lands, even mid-transfer (data corruption case).
      if (load)         shreg <= load_data;
      else if (rise_ev) shreg <= shift_in(shreg, sdi);
    end
  end
endmodule

// File: rtl/ssp_flags.sv
module ssp_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic stat_rd,
  input  logic data_acc,
  input  logic in_window,
  input  logic last_rise,
  output logic done,
  output logic coll,
  output logic armed,
  output logic step2,
  output logic coll_hit
);
  assign step2    = data_acc && armed;
  assign coll_hit = data_acc && in_window;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done  <= 1'b0;
      coll  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (last_rise)  done <= 1'b1;
      else if (step2) done <= 1'b0;

      if (!en)           coll <= 1'b0;
      else if (coll_hit) coll <= 1'b1;
      else if (step2)    coll <= 1'b0;

      if (!en || step2)         armed <= 1'b0;
      else if (stat_rd && done) armed <= 1'b1;
    end
  end
endmodule

// File: rtl/ssp_core.sv
module ssp_core #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_en,
  input  logic [7:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck,
  output logic       sdo,
  input  logic       sdi
);
  import ssp_pkg::*;

  localparam int BITS = 8;

  logic            stat_rd, data_rd, data_wr, data_acc;
  logic            start, tick, busy, in_window, last_rise;
  logic            done, coll, armed, step2, coll_hit;
  logic [BITS-1:0] shreg;

  assign stat_rd  = bus_rd && (bus_addr == SSP_STAT_ADDR);
  assign data_rd  = bus_rd && (bus_addr == SSP_DATA_ADDR);
  assign data_wr  = bus_wr && (bus_addr == SSP_DATA_ADDR);
  assign data_acc = data_rd || data_wr;
  assign start    = data_wr && port_en && !busy;

  ssp_divider #(.HALF(HALF)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  ssp_shifter #(.BITS(BITS)) u_shf (
    .clk(clk), .rst_n(rst_n), .en(port_en), .start(start), .load(data_wr),
    .load_data(bus_wdata), .tick(tick), .sdi(sdi), .sck(sck), .sdo(sdo),
    .busy(busy), .in_window(in_window), .last_rise(last_rise), .shreg(shreg)
  );

  ssp_flags u_flg (
    .clk(clk), .rst_n(rst_n), .en(port_en), .stat_rd(stat_rd),
    .data_acc(data_acc), .in_window(in_window), .last_rise(last_rise),
    .done(done), .coll(coll), .armed(armed), .step2(step2), .coll_hit(coll_hit)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (stat_rd)      bus_rdata = status_word(done, coll);
    else if (data_rd) bus_rdata = shreg;
  end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       stat_rd,
  input logic       data_acc,
  input logic       in_window,
  input logic       last_rise,
  input logic       busy,
  input logic       sck,
  input logic       done,
  input logic       coll,
  input logic       armed,
  input logic [7:0] rdata
);
  p_status_rsvd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |-> (rdata[5:0] == 6'd0));

  p_idle_sck_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> sck);

  p_done_on_last_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(last_rise));

  p_done_clear_seq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(data_acc && armed));

  p_arm_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && en && !data_acc) |=> armed);

  p_coll_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll) |-> $past(data_acc && in_window));

  p_coll_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (coll && !done && en) |=> coll);

  p_disable_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!coll && !armed && sck));
endmodule

bind ssp_core ssp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .en(port_en), .stat_rd(stat_rd),
  .data_acc(data_acc), .in_window(in_window), .last_rise(last_rise),
  .busy(busy), .sck(sck), .done(done), .coll(coll), .armed(armed),
  .rdata(bus_rdata)
);

// File: tb/sim_ssp_core.sv
`timescale 1ns/1ps
module sim_ssp_core;
  localparam int HALF = 2;
  localparam int XFER = 16 * HALF;
  localparam logic [7:0] STAT = 8'h0B;
  localparam logic [7:0] DATA = 8'h0C;
  // tx byte in [15:8], byte presented on SDI in [7:0]
  localparam logic [15:0] VEC [5] = '{16'hA53C, 16'h00FF, 16'hFF00, 16'h817E, 16'h5AC3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [7:0] addr = 8'h00;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic sck, sdo;
  logic sdi = 1'b0;

  int total = 0, bad = 0;
  logic finished = 1'b0;
  logic [7:0] rx_sh = 8'h00;
  logic [7:0] tx_cap = 8'h00;
  int falls = 0;

  always #10 clk = ~clk;

  ssp_core #(.HALF(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .port_en(en), .bus_addr(addr), .bus_rd(rd),
    .bus_wr(wr), .bus_wdata(wdata), .bus_rdata(rdata), .sck(sck), .sdo(sdo),
    .sdi(sdi)
  );

  always @(negedge sck) begin
    sdi   = rx_sh[7];
    rx_sh = {rx_sh[6:0], 1'b0};
    falls = falls + 1;
  end

  always @(posedge sck) tx_cap = {tx_cap[6:0], sdo};

  task automatic chk(input logic ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic expect_stat(input logic [7:0] exp, input string req);
    logic [7:0] v;
    bus_rd(STAT, v);
    chk(v == exp, req, v, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=00 expected=01");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(sck == 1'b1, "R1 sck", {7'd0, sck}, 8'h01);
    chk(sdo == 1'b0, "R1 sdo", {7'd0, sdo}, 8'h00);
    expect_stat(8'h00, "R1 status");
    bus_rd(DATA, v); chk(v == 8'h00, "R1 data", v, 8'h00);
    // R2 unmapped address
    bus_rd(8'h0D, v); chk(v == 8'h00, "R2 unmapped", v, 8'h00);

    // Table walk: R3 R4 R5 R6
    foreach (VEC[i]) begin
      rx_sh = VEC[i][7:0]; tx_cap = 8'h00;
      bus_wr(DATA, VEC[i][15:8]);
      repeat (XFER - 1) @(negedge clk);
      expect_stat(8'h00, "R5 done early");
      expect_stat(8'h80, "R5 done due / R2 layout");
      chk(tx_cap == VEC[i][15:8], "R3 sdo msb first", tx_cap, VEC[i][15:8]);
      bus_rd(DATA, v); chk(v == VEC[i][7:0], "R4 received", v, VEC[i][7:0]);
      expect_stat(8'h00, "R6 cleared");
    end

    // R6 negative, R7 arming survives other accesses
    rx_sh = 8'h00;
    bus_wr(DATA, 8'h96);
    repeat (XFER) @(negedge clk);
    bus_rd(DATA, v);
    expect_stat(8'h80, "R6 no clear without step one");
    bus_rd(8'h05, v);
    bus_wr(8'h05, 8'hEE);
    bus_rd(DATA, v);
    expect_stat(8'h00, "R7 arm kept");

    // R8 access before first fall: no collision
    rx_sh = 8'h3C;
    bus_wr(DATA, 8'h55);
    bus_rd(DATA, v);
    repeat (XFER) @(negedge clk);
    expect_stat(8'h80, "R8 no coll before fall");
    bus_rd(DATA, v);
    expect_stat(8'h00, "R6 cleared after pre-fall test");

    // R8 collision inside window, write not blocked
    rx_sh = 8'h00; tx_cap = 8'h00;
    bus_wr(DATA, 8'hF0);
    repeat (HALF) @(negedge clk);
    bus_wr(DATA, 8'h0F);
    repeat (XFER) @(negedge clk);
    expect_stat(8'hC0, "R8 coll set");
    chk(tx_cap != 8'hF0, "R8 write not blocked", tx_cap, 8'hF0);
    bus_rd(DATA, v);
    expect_stat(8'h00, "R6 both flags cleared");

    // R10 step two inside a new transfer window, R9 done sets again
    bus_wr(DATA, 8'h11);
    repeat (XFER) @(negedge clk);
    bus_wr(DATA, 8'h22);
    expect_stat(8'h80, "R10 arm during transfer");
    repeat (HALF) @(negedge clk);
    bus_rd(DATA, v);
    expect_stat(8'h40, "R10 coll reset by late step two");
    repeat (XFER) @(negedge clk);
    expect_stat(8'hC0, "R9 done set again");
    bus_rd(DATA, v);
    expect_stat(8'h00, "R6 clear before R11");

    // R11 coll with done clear: only enable low clears it
    bus_wr(DATA, 8'h44);
    repeat (HALF + 1) @(negedge clk);
    bus_rd(DATA, v);
    expect_stat(8'h40, "R11 coll without done");
    bus_rd(DATA, v);
    expect_stat(8'h40, "R11 status+data does not clear");
    en = 1'b0;
    @(negedge clk);
    en = 1'b1;
    chk(sck == 1'b1, "R11 sck high after disable", {7'd0, sck}, 8'h01);
    expect_stat(8'h00, "R11 disable clears coll");
    repeat (XFER) @(negedge clk);
    expect_stat(8'h00, "R11 transfer aborted");

    // R12 write while disabled
    en = 1'b0;
    f0 = falls;
    bus_wr(DATA, 8'h77);
    repeat (XFER) @(negedge clk);
    chk(falls == f0, "R12 no sck activity", 8'(falls - f0), 8'h00);
    expect_stat(8'h00, "R12 status");
    bus_rd(DATA, v); chk(v == 8'h77, "R12 data loaded", v, 8'h77);
    en = 1'b1;
    @(negedge clk);

    // R13 reset clears flags
    bus_wr(DATA, 8'hAA);
    repeat (HALF + 1) @(negedge clk);
    bus_wr(DATA, 8'hBB);
    repeat (XFER) @(negedge clk);
    expect_stat(8'hC0, "R13 precondition");
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_stat(8'h00, "R13 flags cleared by reset");

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule